// File: doc/BRIEF.md
# Two-Wire Debug Frame Master

This block is the line-level master for a two-wire microcontroller debug and programming link. It owns a clock line, which also serves as the target's reset line, and a bidirectional data line. It turns single-byte host requests into complete bit-serial frames. Four operations are available: address-register write, address-register read, data-register write and data-register read. A target reset request and an access enable are also provided. Each frame is a sequence of short clock strobes. The data line is either driven ahead of a strobe or released and sampled after it.

The host drives `access_en_i` high to take the pins, then pulses `start_i` with an operation code and, for writes, a byte. The block raises `busy_o` and shifts the frame out. It then returns one `done_o` pulse together with `err_o` and, after a read, the received byte on `rdata_o`. Data-register frames include a handshake field in which the block polls the target, with a bounded number of attempts. Strobe widths come from a parameter giving system clocks per microsecond, so a strobe can never stretch into a reset.

Top module: `twd_frame_master`

## Requirements
- R1: While `access_en_i` is low, `ck_oe_o` and `d_oe_o` are low, `ck_o` is high, and both `start_i` and `tgt_reset_i` are ignored: `busy_o` stays low and no strobe occurs.
- R2: With access enabled and no frame in progress, `ck_oe_o` is high, `ck_o` is high and `d_oe_o` is low.
- R3: In every frame strobe, `ck_o` is low for exactly CLKS_PER_US*STRB_LOW_US cycles and then high for at least CLKS_PER_US*STRB_HIGH_US cycles. The data pin state does not change while `ck_o` is low.
- R4: Every frame opens with one strobe with the data line released and closes with one strobe with the data line released. A frame that times out ends without the closing strobe.
- R5: `op_i` encodes 0 = address write, 1 = address read, 2 = data write, 3 = data read. The two instruction strobes that follow the opening strobe drive, in transmit order, 1,1 / 0,1 / 1,0 / 0,0 respectively.
- R6: Data-register frames drive two further strobes with value 0,0, meaning a one-byte length, directly after the instruction.
- R7: Write frames drive the byte `wdata_i` LSB first, one bit per strobe, with the bit set before the strobe's low phase.
- R8: Read frames release the data line for eight strobes and sample it after each strobe, LSB first. The byte appears on `rdata_o` at `done_o` and is held until the next successful read.
- R9: Data-register frames contain a wait field. The line is released and strobed repeatedly until a sample reads 1. For a data write the field follows the byte; for a data read it precedes the byte.
- R10: If WAIT_TRIES consecutive wait samples read 0, the frame ends with `done_o` and `err_o` high, without a closing strobe, and `rdata_o` stays unchanged.
- R11: A target reset drives `ck_o` low for CLKS_PER_US*RST_LOW_US cycles with the data line released. The block then holds the clock high for CLKS_PER_US*RST_POST_US cycles and ends with `done_o` and `err_o` low. The reset request takes priority over `start_i`.
- R12: `busy_o` rises the cycle after an accepted request and falls with a one-cycle `done_o` pulse. A `start_i` seen while busy has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| access_en_i | input | 1 | Take ownership of the two target pins |
| start_i | input | 1 | Request one frame (idle only) |
| op_i | input | 2 | Operation code, see R5 |
| wdata_i | input | 8 | Byte to send on write operations |
| tgt_reset_i | input | 1 | Request a long clock-low target reset |
| busy_o | output | 1 | Frame or reset in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Wait-field timeout, valid with done |
| rdata_o | output | 8 | Last byte read |
| ck_o | output | 1 | Clock line value |
| ck_oe_o | output | 1 | Clock line output enable |
| d_o | output | 1 | Data line drive value |
| d_oe_o | output | 1 | Data line output enable |
| d_i | input | 1 | Data line sampled value |

## Verification
The bench builds the block with CLKS_PER_US = 4 and keeps the other defaults. A strobe then takes nine cycles and a reset pulse 100, so full 20-try wait timeouts and many random frames fit in a short run. WAIT_TRIES stays at 20, which puts both the 19-low success boundary and the 20-low timeout within reach of directed tests.

// File: rtl/twd_pkg.sv
package twd_pkg;
  typedef enum logic [1:0] {
    OP_AR_WR = 2'd0,
    OP_AR_RD = 2'd1,
    OP_DR_WR = 2'd2,
    OP_DR_RD = 2'd3
  } twd_op_e;

  typedef enum logic [2:0] {
    G_IDLE, G_LOW, G_HIGH, G_RLOW, G_RHIGH
  } gen_st_e;

  typedef enum logic [2:0] {
    F_IDLE, F_START, F_INS, F_LEN, F_DATA, F_WAIT, F_STOP, F_RST
  } frm_st_e;

  // bit [0] goes on the line first
  function automatic logic [1:0] ins_bits(twd_op_e op);
    case (op)
      OP_AR_WR: ins_bits = 2'b11;
      OP_AR_RD: ins_bits = 2'b10;
      OP_DR_WR: ins_bits = 2'b01;
      default:  ins_bits = 2'b00;
    endcase
  endfunction
endpackage

// File: rtl/twd_strobe_gen.sv
module twd_strobe_gen
  import twd_pkg::*;
#(
  parameter int unsigned LOW_CYC   = 100,
  parameter int unsigned HIGH_CYC  = 100,
  parameter int unsigned RLOW_CYC  = 2500,
  parameter int unsigned RHIGH_CYC = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strb_go_i,
  input  logic rst_go_i,
  output logic ck_o,
  output logic slot_end_o
);
  localparam int unsigned M1 = (LOW_CYC > HIGH_CYC) ? LOW_CYC : HIGH_CYC;
  localparam int unsigned M2 = (RLOW_CYC > RHIGH_CYC) ? RLOW_CYC : RHIGH_CYC;
  localparam int unsigned MAXC = (M1 > M2) ? M1 : M2;
  localparam int CW = $clog2(MAXC + 1);

  gen_st_e st_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= G_IDLE;
      cnt_q <= '0;
    end else begin
      case (st_q)
        G_IDLE: begin
          if (rst_go_i) begin
            st_q  <= G_RLOW;
            cnt_q <= CW'(RLOW_CYC - 1);
          end else if (strb_go_i) begin
            st_q  <= G_LOW;
            cnt_q <= CW'(LOW_CYC - 1);
          end
        end
        G_LOW, G_RLOW: begin
          if (cnt_q == '0) begin
            st_q  <= (st_q == G_LOW) ? G_HIGH : G_RHIGH;
            cnt_q <= (st_q == G_LOW) ? CW'(HIGH_CYC - 1) : CW'(RHIGH_CYC - 1);
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: begin
          if (cnt_q == '0) st_q <= G_IDLE;
          else             cnt_q <= cnt_q - 1'b1;
        end
      endcase
    end
  end

  assign ck_o       = !(st_q == G_LOW || st_q == G_RLOW);
  assign slot_end_o = (st_q == G_HIGH || st_q == G_RHIGH) && (cnt_q == '0);
endmodule

// File: rtl/twd_frame_seq.sv
module twd_frame_seq
  import twd_pkg::*;
#(
  parameter int unsigned WAIT_TRIES = 20
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       access_en_i,
  input  logic       start_i,
  input  logic [1:0] op_i,
  input  logic [7:0] wdata_i,
  input  logic       tgt_reset_i,
  input  logic       slot_end_i,
  input  logic       d_i,
  output logic       strb_go_o,
  output logic       rst_go_o,
  output logic       d_o,
  output logic       d_oe_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       err_o,
  output logic [7:0] rdata_o
);
  localparam int WW = $clog2(WAIT_TRIES + 1);

  frm_st_e       st_q;
  logic [1:0]    op_q;
  logic [7:0]    sh_q;
  logic [2:0]    idx_q;
  logic [WW-1:0] wcnt_q;
  logic [1:0]    ins;

  assign ins = ins_bits(twd_op_e'(op_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= F_IDLE; op_q <= '0; sh_q <= '0; idx_q <= '0; wcnt_q <= '0;
      strb_go_o <= 1'b0; rst_go_o <= 1'b0; d_o <= 1'b0; d_oe_o <= 1'b0;
      busy_o <= 1'b0; done_o <= 1'b0; err_o <= 1'b0; rdata_o <= '0;
    end else begin
      strb_go_o <= 1'b0;
      rst_go_o  <= 1'b0;
      done_o    <= 1'b0;
      if (st_q == F_IDLE) begin
        if (access_en_i && tgt_reset_i) begin
          st_q <= F_RST; rst_go_o <= 1'b1; busy_o <= 1'b1;
          err_o <= 1'b0; d_oe_o <= 1'b0;
        end else if (access_en_i && start_i) begin
          st_q <= F_START; strb_go_o <= 1'b1; busy_o <= 1'b1;
          err_o <= 1'b0; d_oe_o <= 1'b0; op_q <= op_i; sh_q <= wdata_i;
        end
      end else if (slot_end_i) begin
        strb_go_o <= 1'b1;
        idx_q     <= '0;
        case (st_q)
          F_START: begin
            st_q <= F_INS; d_oe_o <= 1'b1; d_o <= ins[0];
          end
          F_INS: begin
            if (idx_q == 3'd0) begin
              idx_q <= 3'd1; d_o <= ins[1];
            end else if (op_q[1]) begin
              st_q <= F_LEN; d_o <= 1'b0;
            end else begin
              st_q <= F_DATA; d_o <= sh_q[0]; d_oe_o <= !op_q[0];
            end
          end
          F_LEN: begin
            if (idx_q == 3'd0) begin
              idx_q <= 3'd1; d_o <= 1'b0;
            end else if (!op_q[0]) begin
              st_q <= F_DATA; d_o <= sh_q[0];
            end else begin
              st_q <= F_WAIT; d_oe_o <= 1'b0; wcnt_q <= '0;
            end
          end
          F_DATA: begin
            if (op_q[0]) begin
              sh_q <= {d_i, sh_q[7:1]};
            end else begin
              sh_q <= {1'b0, sh_q[7:1]};
              d_o  <= sh_q[1];
            end
            idx_q <= idx_q + 1'b1;
            if (idx_q == 3'd7) begin
              d_oe_o <= 1'b0;
              wcnt_q <= '0;
              st_q   <= (op_q == OP_DR_WR) ? F_WAIT : F_STOP;
            end
          end
          F_WAIT: begin
            if (d_i) begin
              st_q <= op_q[0] ? F_DATA : F_STOP;
            end else if (wcnt_q == WW'(WAIT_TRIES - 1)) begin
              st_q <= F_IDLE; strb_go_o <= 1'b0;
              busy_o <= 1'b0; done_o <= 1'b1; err_o <= 1'b1;
            end else begin
              wcnt_q <= wcnt_q + 1'b1;
            end
          end
          F_STOP: begin
            st_q <= F_IDLE; strb_go_o <= 1'b0;
            busy_o <= 1'b0; done_o <= 1'b1;
            if (op_q[0]) rdata_o <= sh_q;
          end
          default: begin
            st_q <= F_IDLE; strb_go_o <= 1'b0;
            busy_o <= 1'b0; done_o <= 1'b1;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/twd_frame_master.sv
module twd_frame_master
  import twd_pkg::*;
#(
  parameter int unsigned CLKS_PER_US  = 100,
  parameter int unsigned STRB_LOW_US  = 1,
  parameter int unsigned STRB_HIGH_US = 1,
  parameter int unsigned RST_LOW_US   = 25,
  parameter int unsigned RST_POST_US  = 1,
  parameter int unsigned WAIT_TRIES   = 20
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       access_en_i,
  input  logic       start_i,
  input  logic [1:0] op_i,
  input  logic [7:0] wdata_i,
  input  logic       tgt_reset_i,
  output logic       busy_o,
  output logic       done_o,
  output logic       err_o,
  output logic [7:0] rdata_o,
  output logic       ck_o,
  output logic       ck_oe_o,
  output logic       d_o,
  output logic       d_oe_o,
  input  logic       d_i
);
  localparam int unsigned LOW_CYC   = CLKS_PER_US * STRB_LOW_US;
  localparam int unsigned HIGH_CYC  = CLKS_PER_US * STRB_HIGH_US;
  localparam int unsigned RLOW_CYC  = CLKS_PER_US * RST_LOW_US;
  localparam int unsigned RHIGH_CYC = CLKS_PER_US * RST_POST_US;

  logic strb_go, rst_go, slot_end, doe;

  twd_strobe_gen #(
    .LOW_CYC(LOW_CYC), .HIGH_CYC(HIGH_CYC),
    .RLOW_CYC(RLOW_CYC), .RHIGH_CYC(RHIGH_CYC)
  ) gen_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .strb_go_i(strb_go), .rst_go_i(rst_go),
    .ck_o(ck_o), .slot_end_o(slot_end)
  );

  twd_frame_seq #(.WAIT_TRIES(WAIT_TRIES)) seq_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .access_en_i(access_en_i),
    .start_i(start_i), .op_i(op_i), .wdata_i(wdata_i),
    .tgt_reset_i(tgt_reset_i), .slot_end_i(slot_end), .d_i(d_i),
    .strb_go_o(strb_go), .rst_go_o(rst_go), .d_o(d_o), .d_oe_o(doe),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .rdata_o(rdata_o)
  );

  // clock is already high whenever idle, so enabling its driver never glitches low
  assign ck_oe_o = access_en_i;
  assign d_oe_o  = access_en_i & doe;
endmodule

// File: rtl/twd_frame_master_chk.sv
module twd_frame_master_chk #(
  parameter int unsigned RLOW_CYC = 2500
) (
  input logic clk_i,
  input logic rst_ni,
  input logic access_en_i,
  input logic busy_o,
  input logic done_o,
  input logic err_o,
  input logic ck_o,
  input logic ck_oe_o,
  input logic d_o,
  input logic d_oe_o
);
  localparam int CW = $clog2(RLOW_CYC + 2);
  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    low_cnt <= '0;
    else if (!ck_o) low_cnt <= low_cnt + 1'b1;
    else            low_cnt <= '0;
  end

  assert_access_off_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !access_en_i |-> (!ck_oe_o && !d_oe_o && ck_o && !busy_o));

  assert_idle_ck_high_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ck_oe_o && !busy_o) |-> (ck_o && !d_oe_o));

  assert_low_bounded_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    low_cnt <= CW'(RLOW_CYC));

  assert_data_still_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ck_o && $past(!ck_o)) |-> ($stable(d_o) && $stable(d_oe_o)));

  assert_open_released_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !d_oe_o);

  assert_timeout_released_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o) |-> !d_oe_o);

  assert_done_pulse_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_not_busy_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
endmodule

bind twd_frame_master twd_frame_master_chk #(
  .RLOW_CYC(CLKS_PER_US * RST_LOW_US)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .access_en_i(access_en_i),
  .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .ck_o(ck_o),
  .ck_oe_o(ck_oe_o), .d_o(d_o), .d_oe_o(d_oe_o)
);

// File: tb/twd_frame_master_tb_top.sv
`timescale 1ns/1ps
module twd_frame_master_tb_top;
  localparam int CPU   = 4;
  localparam int LOWC  = CPU;
  localparam int RLOWC = 25 * CPU;
  localparam int TRIES = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic access_en = 1'b0, start = 1'b0, tgt_rst = 1'b0, d_in = 1'b1;
  logic [1:0] op = '0;
  logic [7:0] wdata = '0;
  logic busy, done, err, ck, ck_oe, d_out, d_oe;
  logic [7:0] rdata;

  always #5 clk = ~clk;

  twd_frame_master #(.CLKS_PER_US(CPU)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .access_en_i(access_en), .start_i(start),
    .op_i(op), .wdata_i(wdata), .tgt_reset_i(tgt_rst), .busy_o(busy),
    .done_o(done), .err_o(err), .rdata_o(rdata), .ck_o(ck), .ck_oe_o(ck_oe),
    .d_o(d_out), .d_oe_o(d_oe), .d_i(d_in)
  );

  int n_cmp = 0, n_bad = 0;
  int exp_n, mon_k, bad_low, exp_low, lowc;
  logic exp_oe [64];
  logic exp_v  [64];
  logic resp   [64];
  logic log_oe [64];
  logic log_v  [64];
  logic prev_ck = 1'b1;
  logic [7:0] exp_rd = '0;

  task automatic chk(input logic ok, input string req, input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // target model: one slot per falling clock edge, response presented for that strobe
  always @(negedge clk) begin
    if (!ck) lowc++;
    if (prev_ck && !ck) begin
      if (mon_k < 64) begin
        log_oe[mon_k] = d_oe;
        log_v[mon_k]  = d_out;
        d_in = resp[mon_k];
      end
      mon_k++;
    end
    if (!prev_ck && ck) begin
      if (lowc != exp_low) bad_low++;
      lowc = 0;
    end
    prev_ck = ck;
  end

  task automatic add(input logic oe, input logic v, input logic r);
    exp_oe[exp_n] = oe; exp_v[exp_n] = v; resp[exp_n] = r; exp_n++;
  endtask

  function automatic logic ins_first(input int o);
    return (o == 0 || o == 2);
  endfunction
  function automatic logic ins_second(input int o);
    return (o == 0 || o == 1);
  endfunction

  task automatic build(input int o, input logic [7:0] w, input logic [7:0] rb,
                       input int nlo, output logic tmo);
    exp_n = 0;
    for (int i = 0; i < 64; i++) resp[i] = 1'b1;
    tmo = (o >= 2) && (nlo >= TRIES);
    add(0, 0, 1);
    add(1, ins_first(o), 1);
    add(1, ins_second(o), 1);
    if (o >= 2) begin add(1, 0, 1); add(1, 0, 1); end
    if (o == 0 || o == 2) for (int i = 0; i < 8; i++) add(1, w[i], 1);
    if (o == 1) for (int i = 0; i < 8; i++) add(0, 0, rb[i]);
    if (o >= 2) begin
      for (int j = 0; j < ((nlo < TRIES) ? nlo : TRIES); j++) add(0, 0, 0);
      if (!tmo) add(0, 0, 1);
    end
    if (o == 3 && !tmo) for (int i = 0; i < 8; i++) add(0, 0, rb[i]);
    if (!tmo) add(0, 0, 1);
  endtask

  task automatic wait_done(input string req);
    int t = 0;
    while (!done && t < 3000) begin @(negedge clk); t++; end
    chk(done, req, 0, 1);
  endtask

  task automatic run_op(input int o, input logic [7:0] w, input logic [7:0] rb,
                        input int nlo, input logic poke);
    logic tmo;
    int frame_ok;
    build(o, w, rb, nlo, tmo);
    mon_k = 0; bad_low = 0; exp_low = LOWC;
    @(negedge clk);
    start = 1'b1; op = 2'(o); wdata = w;
    @(negedge clk);
    start = 1'b0;
    chk(busy, "R12 busy after start", busy, 1);
    if (poke) begin
      repeat (30) @(negedge clk);
      start = 1'b1; op = 2'(3 - o); wdata = ~w;
      @(negedge clk);
      start = 1'b0;
    end
    wait_done("R12 done");
    frame_ok = (mon_k == exp_n);
    for (int i = 0; i < exp_n && i < 64; i++)
      if (log_oe[i] !== exp_oe[i] || (exp_oe[i] && log_v[i] !== exp_v[i])) frame_ok = 0;
    chk(frame_ok != 0, "R4 R5 R6 R7 R9 frame slots", mon_k, exp_n);
    chk(err == tmo, "R10 err flag", err, tmo);
    if ((o == 1 || o == 3) && !tmo) exp_rd = rb;
    chk(rdata == exp_rd, "R8 R10 read byte", rdata, exp_rd);
    chk(bad_low == 0, "R3 strobe low width", bad_low, 0);
    @(negedge clk);
    chk(!done && !busy, "R12 done single pulse", done, 0);
    chk(ck && ck_oe && !d_oe, "R2 idle lines", {ck, ck_oe, d_oe}, 3'b110);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] w, rb;
    int o, nlo;
    mon_k = 0; lowc = 0; exp_low = LOWC; bad_low = 0;
    void'($urandom(32'd11));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state and ignored requests while access is off
    chk(ck && !ck_oe && !d_oe && !busy && !done, "R1 reset state",
        {ck, ck_oe, d_oe, busy, done}, 5'b10000);
    start = 1'b1; tgt_rst = 1'b1;
    @(negedge clk);
    start = 1'b0; tgt_rst = 1'b0;
    repeat (40) @(negedge clk);
    chk(!busy && mon_k == 0 && ck, "R1 requests ignored", mon_k, 0);
    // R2: enabling access
    access_en = 1'b1;
    @(negedge clk);
    chk(ck_oe && ck && !d_oe, "R2 access on", {ck_oe, ck, d_oe}, 3'b110);
    // R11: target reset, priority over start
    mon_k = 0; bad_low = 0; exp_low = RLOWC;
    for (int i = 0; i < 64; i++) resp[i] = 1'b1;
    tgt_rst = 1'b1; start = 1'b1;
    @(negedge clk);
    tgt_rst = 1'b0; start = 1'b0;
    wait_done("R11 reset done");
    chk(mon_k == 1 && bad_low == 0 && !err && log_oe[0] == 1'b0,
        "R11 reset pulse", mon_k, 1);
    // directed frames
    run_op(0, 8'hA5, 8'h00, 0, 1'b0);
    run_op(1, 8'h00, 8'h3C, 0, 1'b0);
    run_op(2, 8'h81, 8'h00, 0, 1'b0);
    run_op(3, 8'h00, 8'hC6, 0, 1'b0);
    run_op(2, 8'h5A, 8'h00, TRIES - 1, 1'b0);  // R9 last try succeeds
    run_op(3, 8'h00, 8'h7E, TRIES - 1, 1'b0);
    run_op(2, 8'hFF, 8'h00, TRIES, 1'b0);      // R10 timeout on write
    run_op(3, 8'h00, 8'h12, TRIES, 1'b0);      // R10 timeout on read keeps rdata
    run_op(1, 8'h00, 8'hE7, 0, 1'b1);          // R12 start while busy ignored
    // random frames
    for (int n = 0; n < 40; n++) begin
      o   = $urandom_range(0, 3);
      w   = 8'($urandom);
      rb  = 8'($urandom);
      nlo = ($urandom_range(0, 7) == 0) ? $urandom_range(0, TRIES) : $urandom_range(0, 3);
      run_op(o, w, rb, nlo, 1'b0);
    end
    // R1 again: drop access, start ignored
    access_en = 1'b0;
    mon_k = 0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    chk(!busy && mon_k == 0 && !ck_oe && !d_oe, "R1 access off again", mon_k, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule